// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block keeps the two threshold values that a FIFO's flag logic compares against: an empty-side offset for the almost-empty flag and a full-side offset for the almost-full flag. While master reset is held, it samples a load-mode strap and a two-bit default-select strap. From these it presets both offsets to one of eight powers-of-two-minus-one. The load mode stays fixed until the next master reset.

After reset, offsets arrive on a valid/ready load stream in one of two ways. In parallel mode each accepted beat carries a whole word. In serial mode each accepted beat carries one bit, least significant first. In both modes the empty-side register is filled first and the full-side register second, and the cycle then repeats. `ld_ready` is low only during master reset, so the loader applies back-pressure only then.

The current offsets can be read back as words on a valid/ready output stream in the read clock domain, whatever the load mode. `rb_valid` is high whenever master reset is released. `rb_word` shows the register named by a readback pointer, and each accepted beat (`rb_valid && rb_ready`) moves that pointer to the other register. There is no serial readback.

Top module: `flagofs_loader`

## Requirements
- R1: The load mode is taken from `strap_serial` while `mrst` is high (1 = serial, 0 = parallel). Changing `strap_serial` after `mrst` falls has no effect on how later beats are interpreted.
- R2: While `mrst` is high, both offsets are preset to 2^(7+k)-1, where k = {strap_serial, strap_sel[1], strap_sel[0]} read as a 3-bit number. This gives 127, 255, 511, 1023 with `strap_serial` low and 2047, 4095, 8191, 16383 with it high.
- R3: Right after reset, `empty_ofs` equals `full_ofs`.
- R4: In parallel mode, the first accepted in-range word after reset goes to `empty_ofs`, the next to `full_ofs`, and so on alternating. Each register updates at the clock edge that accepts the beat.
- R5: In serial mode, `ld_bit` is shifted in least significant bit first, one bit per accepted beat. After OFS_W beats the value is committed to `empty_ofs`, and after the next OFS_W beats to `full_ofs`, alternating from then on. A register does not change before its last bit is accepted.
- R6: In serial mode `ld_word` has no effect, and in parallel mode `ld_bit` has no effect.
- R7: A value of DEPTH or more is discarded and leaves both registers unchanged. In parallel mode the write pointer does not advance; in serial mode the pointer still moves on to the other register.
- R8: `rb_word` shows `empty_ofs` after reset. Each readback beat switches it between the full-side and empty-side register, in either load mode, using a pointer separate from the write side.
- R9: While `mrst` is high, `ld_ready` and `rb_valid` are low.
- R10: Offsets can be rewritten any number of times after reset, and without an accepted load beat neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Load-side clock |
| rclk | input | 1 | Readback-side clock |
| mrst | input | 1 | Master reset, active high, synchronous |
| strap_serial | input | 1 | Load-mode strap, sampled during reset (1 = serial) |
| strap_sel | input | 2 | Default-offset select strap, sampled during reset |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat ready (low during reset) |
| ld_word | input | OFS_W | Parallel offset word |
| ld_bit | input | 1 | Serial offset bit |
| rb_valid | output | 1 | Readback word valid |
| rb_ready | input | 1 | Readback consumer ready |
| rb_word | output | OFS_W | Offset selected by the readback pointer |
| empty_ofs | output | OFS_W | Almost-empty offset for the flag logic |
| full_ofs | output | OFS_W | Almost-full offset for the flag logic |

## Verification
A parallel word, or the last bit of a serial value, shows up on `empty_ofs`/`full_ofs` right after the `wclk` edge that accepts it. Defaults are present as soon as one edge has passed with `mrst` high. `rb_word` changes after the `rclk` edge that accepts a readback beat. The bench changes inputs on falling edges, holds each beat for exactly one rising edge, and reads the outputs at the next falling edge. It also checks a serial register one bit before its commit, to show that it has not yet changed.

// File: rtl/flagofs_pkg.sv
package flagofs_pkg;
  typedef enum logic {LOAD_PAR = 1'b0, LOAD_SER = 1'b1} load_mode_e;
  typedef enum logic {SLOT_EMPTY = 1'b0, SLOT_FULL = 1'b1} slot_e;

  localparam int unsigned DFLT_BASE_EXP = 7;

  function automatic logic [31:0] default_offset(input logic [2:0] idx);
    return (32'd1 << (DFLT_BASE_EXP + 32'(idx))) - 32'd1;
  endfunction

  function automatic slot_e other_slot(input slot_e s);
    return (s == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
  endfunction
endpackage

// File: rtl/flagofs_defaults.sv
module flagofs_defaults
  import flagofs_pkg::*;
#(
  parameter int OFS_W = 15
) (
  input  logic             serial_strap,
  input  logic [1:0]       sel_strap,
  output logic [OFS_W-1:0] value
);
  logic [2:0]  idx;
  logic [31:0] full_val;

  always_comb begin
    idx      = {serial_strap, sel_strap};
    full_val = default_offset(idx);
    value    = full_val[OFS_W-1:0];
  end
endmodule

// File: rtl/flagofs_serial_shift.sv
module flagofs_serial_shift #(
  parameter int OFS_W = 15,
  localparam int CW   = $clog2(OFS_W),
  localparam logic [CW-1:0] LAST = CW'(OFS_W - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic             commit,
  output logic [OFS_W-1:0] value
);
  logic [OFS_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q;

  always_comb begin
    commit = shift_en && (cnt_q == LAST);
    value  = {bit_in, sh_q[OFS_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q  <= value;
      cnt_q <= commit ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/flagofs_readback.sv
module flagofs_readback
  import flagofs_pkg::*;
#(
  parameter int OFS_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [OFS_W-1:0] empty_val,
  input  logic [OFS_W-1:0] full_val,
  output logic [OFS_W-1:0] word
);
  slot_e ptr_q;

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= SLOT_EMPTY;
    else if (take) ptr_q <= other_slot(ptr_q);
  end

  always_comb word = (ptr_q == SLOT_EMPTY) ? empty_val : full_val;
endmodule

// File: rtl/flagofs_loader.sv
module flagofs_loader
  import flagofs_pkg::*;
#(
  parameter int DEPTH = 20000,
  parameter int OFS_W = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst,
  input  logic             strap_serial,
  input  logic [1:0]       strap_sel,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [OFS_W-1:0] ld_word,
  input  logic             ld_bit,
  output logic             rb_valid,
  input  logic             rb_ready,
  output logic [OFS_W-1:0] rb_word,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  load_mode_e       mode_q;
  slot_e            wr_slot_q;
  logic [OFS_W-1:0] empty_q, full_q, dflt_val;
  logic [OFS_W-1:0] ser_val, cand;
  logic             hs, par_hs, ser_hs, ser_commit, take, in_range, take_ok;

  flagofs_defaults #(.OFS_W(OFS_W)) u_dflt (
    .serial_strap (strap_serial),
    .sel_strap    (strap_sel),
    .value        (dflt_val)
  );

  flagofs_serial_shift #(.OFS_W(OFS_W)) u_ser (
    .clk      (wclk),
    .rst      (mrst),
    .shift_en (ser_hs),
    .bit_in   (ld_bit),
    .commit   (ser_commit),
    .value    (ser_val)
  );

  always_comb begin
    ld_ready = !mrst;
    hs       = ld_valid && ld_ready;
    par_hs   = hs && (mode_q == LOAD_PAR);
    ser_hs   = hs && (mode_q == LOAD_SER);
    cand     = (mode_q == LOAD_PAR) ? ld_word : ser_val;
    take     = par_hs || ser_commit;
    in_range = (32'(cand) < 32'(DEPTH));
    take_ok  = take && in_range;
  end

  always_ff @(posedge wclk) begin
    if (mrst) begin
      mode_q    <= load_mode_e'(strap_serial);
      wr_slot_q <= SLOT_EMPTY;
      empty_q   <= dflt_val;
      full_q    <= dflt_val;
    end else begin
      if (take_ok) begin
        if (wr_slot_q == SLOT_EMPTY) empty_q <= cand;
        else                         full_q  <= cand;
      end
      if (take_ok || ser_commit) wr_slot_q <= other_slot(wr_slot_q);
    end
  end

  always_comb begin
    empty_ofs = empty_q;
    full_ofs  = full_q;
    rb_valid  = !mrst;
  end

  flagofs_readback #(.OFS_W(OFS_W)) u_rb (
    .clk       (rclk),
    .rst       (mrst),
    .take      (rb_valid && rb_ready),
    .empty_val (empty_q),
    .full_val  (full_q),
    .word      (rb_word)
  );
endmodule

// File: rtl/flagofs_loader_chk.sv
module flagofs_loader_chk #(
  parameter int DEPTH = 20000,
  parameter int OFS_W = 15
) (
  input logic             wclk,
  input logic             rclk,
  input logic             mrst,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic             rb_valid,
  input logic [OFS_W-1:0] rb_word,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs
);
  AST_IDLE_HOLDS: assert property (@(posedge wclk) disable iff (mrst)
    !ld_valid |=> ($stable(empty_ofs) && $stable(full_ofs))); // R10

  AST_ONE_SLOT_PER_EDGE: assert property (@(posedge wclk) disable iff (mrst)
    !mrst |=> ($stable(empty_ofs) || $stable(full_ofs))); // R4

  AST_IN_RANGE: assert property (@(posedge wclk) disable iff (mrst)
    !mrst |-> (32'(empty_ofs) < 32'(DEPTH) && 32'(full_ofs) < 32'(DEPTH))); // R7

  AST_DEFAULTS_EQUAL: assert property (@(posedge wclk) disable iff (mrst)
    $fell(mrst) |-> (empty_ofs == full_ofs)); // R3

  AST_RB_IS_OFFSET: assert property (@(posedge rclk) disable iff (mrst)
    rb_valid |-> (rb_word == empty_ofs || rb_word == full_ofs)); // R8

  AST_READY_AFTER_RESET: assert property (@(posedge wclk) disable iff (mrst)
    $fell(mrst) |-> (ld_ready && rb_valid)); // R9
endmodule

bind flagofs_loader flagofs_loader_chk #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_chk (
  .wclk      (wclk),
  .rclk      (rclk),
  .mrst      (mrst),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .rb_valid  (rb_valid),
  .rb_word   (rb_word),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs)
);

// File: tb/flagofs_loader_tb.sv
`timescale 1ns/1ps
module flagofs_loader_tb;
  localparam int DEPTH = 20000;
  localparam int W     = 15;

  // vector: {word, expected empty, expected full}, parallel mode, sel=2 (default 511)
  localparam logic [47:0] PAR_VEC [6] = '{
    {16'd100,   16'd100, 16'd511},
    {16'd200,   16'd100, 16'd200},
    {16'd25000, 16'd100, 16'd200},
    {16'd300,   16'd300, 16'd200},
    {16'd19999, 16'd300, 16'd19999},
    {16'd0,     16'd0,   16'd19999}
  };

  logic clk = 1'b0;
  logic mrst = 1'b1, strap_serial = 1'b0, ld_valid = 1'b0, ld_bit = 1'b0, rb_ready = 1'b0;
  logic [1:0] strap_sel = 2'd0;
  logic [W-1:0] ld_word = '0;
  logic ld_ready, rb_valid;
  logic [W-1:0] rb_word, empty_ofs, full_ofs;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  flagofs_loader #(.DEPTH(DEPTH)) u_dut (
    .wclk(clk), .rclk(clk), .mrst(mrst), .strap_serial(strap_serial),
    .strap_sel(strap_sel), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_word(ld_word), .ld_bit(ld_bit), .rb_valid(rb_valid),
    .rb_ready(rb_ready), .rb_word(rb_word), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic ser, input logic [1:0] sel);
    @(negedge clk);
    mrst = 1'b1; strap_serial = ser; strap_sel = sel; ld_valid = 1'b0; rb_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 ld_ready in reset", 32'(ld_ready), 32'd0);
    chk("R9 rb_valid in reset", 32'(rb_valid), 32'd0);
    mrst = 1'b0;
  endtask

  task automatic par_write(input logic [W-1:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_word = w; ld_bit = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic ser_bits(input logic [W-1:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_bit = v[i]; ld_word = W'(16'h5a5a);
      @(negedge clk);
      ld_valid = 1'b0;
    end
  endtask

  task automatic rb_beat();
    @(negedge clk);
    rb_ready = 1'b1;
    @(negedge clk);
    rb_ready = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R2, R3: all eight defaults
    for (int k = 0; k < 8; k++) begin
      do_reset(k[2], k[1:0]);
      @(negedge clk);
      chk("R2 default empty", 32'(empty_ofs), (32'd1 << (7 + k)) - 1);
      chk("R3 default equal", 32'(full_ofs), 32'(empty_ofs));
    end

    // R4, R7, R10: parallel vector walk; strap changed after reset (R1)
    do_reset(1'b0, 2'd2);
    strap_serial = 1'b1;
    chk("R8 rb after reset", 32'(rb_word), 32'd511);
    for (int i = 0; i < 6; i++) begin
      par_write(W'(PAR_VEC[i][47:32]));
      chk("R4 R1 empty_ofs", 32'(empty_ofs), 32'(PAR_VEC[i][31:16]));
      chk("R4 R7 full_ofs", 32'(full_ofs), 32'(PAR_VEC[i][15:0]));
    end
    // R10: idle cycles keep values
    repeat (3) @(negedge clk);
    chk("R10 idle empty", 32'(empty_ofs), 32'd0);
    chk("R10 idle full", 32'(full_ofs), 32'd19999);
    // R8: readback alternation in parallel mode
    chk("R8 rb first", 32'(rb_word), 32'd0);
    rb_beat();
    chk("R8 rb second", 32'(rb_word), 32'd19999);
    rb_beat();
    chk("R8 rb wrap", 32'(rb_word), 32'd0);

    // R5, R6: serial mode, default 2047
    do_reset(1'b1, 2'd0);
    strap_serial = 1'b0;
    ser_bits(W'(1234), 0, W - 2);
    chk("R5 before last bit", 32'(empty_ofs), 32'd2047);
    ser_bits(W'(1234), W - 1, W - 1);
    chk("R5 R6 empty commit", 32'(empty_ofs), 32'd1234);
    chk("R5 full untouched", 32'(full_ofs), 32'd2047);
    ser_bits(W'(5678), 0, W - 1);
    chk("R5 full commit", 32'(full_ofs), 32'd5678);
    // R7 serial: out of range discarded, pointer moves to full
    ser_bits(W'(30000), 0, W - 1);
    chk("R7 serial discard", 32'(empty_ofs), 32'd1234);
    ser_bits(W'(777), 0, W - 1);
    chk("R7 serial next to full", 32'(full_ofs), 32'd777);
    chk("R7 empty kept", 32'(empty_ofs), 32'd1234);
    // R8 readback in serial mode
    chk("R8 serial rb empty", 32'(rb_word), 32'd1234);
    rb_beat();
    chk("R8 serial rb full", 32'(rb_word), 32'd777);

    // R6: parallel mode ignores ld_bit (par_write drives ld_bit=1)
    do_reset(1'b0, 2'd0);
    par_write(W'(42));
    chk("R6 parallel word", 32'(empty_ofs), 32'd42);
    chk("R9 ready after reset", 32'(ld_ready), 32'd1);

    summary();
    $finish;
  end
endmodule